// File: doc/BRIEF.md
# Product-Term Allocating Function Block

This block is a cluster of macrocells that share one input bus. Each macrocell owns a small fixed set of product terms. Every product term is an AND over chosen true and complemented input literals. Each term has a routing field. The field either keeps the term in its owner's OR sum or hands it to an adjacent macrocell. A macrocell can also pass a partial sum it received on to the next macrocell, so borrowed terms can cross several cells. This lets a single output build a sum-of-products wider than its own term budget.

Each macrocell XORs its sum with a polarity bit. It then presents the result either directly or through a flip-flop on the shared clock. The flip-flop loads a per-cell initial value on asynchronous reset or on a synchronous global set/reset. Each output has its own enable, and a global tri-state control can force every enable low. All configuration arrives on flat input vectors. A configuration loader or register file outside the block holds it.

Top module: `ptalloc_fblock`

## Requirements
- R1: An enabled product term is 1 exactly when every input bit set in its true mask is 1 and every input bit set in its complement mask is 0. A term whose enable bit is 0 is 0.
- R2: In combinational mode, a macrocell output equals the OR of its locally kept terms and the partial sums it absorbs, XORed with its polarity bit.
- R3: A term routed with code 01 is added to macrocell i+1. A term routed with code 10 is added to macrocell i-1. A routed term no longer contributes to its owner's sum.
- R4: When a macrocell's up-chain bit is set, the up-going partial sum it receives is forwarded to macrocell i+1 instead of being absorbed. The down-chain bit does the same toward i-1. Forwarding can span several macrocells.
- R5: Terms with route code 11, terms routed up from the highest macrocell, and terms routed down from macrocell 0 reach no sum.
- R6: When the register-select bit is 1, the output is a flip-flop that captures the combinational value at each rising clock edge. Input changes between edges do not reach the output.
- R7: While rst_n is low, every macrocell flip-flop holds its initial-value bit.
- R8: A high gsr at a rising edge loads every flip-flop with its initial-value bit and overrides the data.
- R9: Output enable i equals oe_cfg[i] while gts is low. All output enables are 0 while gts is high.
- R10: A macrocell that borrows terms from both neighbours evaluates a sum of more than its native term count correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gsr | input | 1 | Synchronous global set/reset to the initial values |
| gts | input | 1 | Global tri-state, forces all enables low |
| in_bus | input | N_IN | Shared input bus |
| pt_en | input | N_MC*N_PT | Term enables, term k of cell m at bit m*N_PT+k |
| pt_true | input | N_MC*N_PT*N_IN | True-literal masks, N_IN bits per term |
| pt_comp | input | N_MC*N_PT*N_IN | Complement-literal masks, N_IN bits per term |
| pt_route | input | 2*N_MC*N_PT | Route code per term: 00 keep, 01 up, 10 down, 11 drop |
| chain_up | input | N_MC | Forward the received up-going sum |
| chain_dn | input | N_MC | Forward the received down-going sum |
| invert | input | N_MC | Output polarity per cell |
| reg_sel | input | N_MC | 1 selects the registered output |
| init_val | input | N_MC | Flip-flop initial value per cell |
| oe_cfg | input | N_MC | Output enable per cell |
| mc_out | output | N_MC | Macrocell outputs |
| mc_oe | output | N_MC | Macrocell output enables |

## Verification
The hardest condition to reach from the ports is a sum built partly from borrowed terms. In that case a wrong term count or a leak back into the donor stays hidden under typical input values. The stimulus assigns each term of the wide function a unique pair of inputs. It then drives one pair at a time, and each single pair alone must raise the borrower's output and leave every donor's output at 0. Multi-hop forwarding is reached by donating a term two cells away with the intermediate cells set to forward. Those intermediate outputs must stay low.

// File: rtl/ptalloc_pkg.sv
package ptalloc_pkg;

   typedef enum logic [1:0] {
      RT_KEEP = 2'b00,
      RT_UP   = 2'b01,
      RT_DOWN = 2'b10,
      RT_DROP = 2'b11
   } route_e;

endpackage

// File: rtl/ptalloc_terms.sv
module ptalloc_terms
   import ptalloc_pkg::*;
#(
   parameter int N_IN = 36,
   parameter int N_PT = 5
) (
   input  logic [N_IN-1:0]      in_bus,
   input  logic [N_PT-1:0]      en,
   input  logic [N_PT*N_IN-1:0] tmask,
   input  logic [N_PT*N_IN-1:0] cmask,
   input  logic [2*N_PT-1:0]    route,
   output logic                 keep_or,
   output logic                 up_or,
   output logic                 dn_or
);

   logic [N_PT-1:0] keep_v;
   logic [N_PT-1:0] up_v;
   logic [N_PT-1:0] dn_v;

   for (genvar k = 0; k < N_PT; k++) begin : g_term
      logic [N_IN-1:0] tm;
      logic [N_IN-1:0] cm;
      logic            hit;
      route_e          rt;

      assign tm  = tmask[k*N_IN +: N_IN];
      assign cm  = cmask[k*N_IN +: N_IN];
      assign hit = en[k] & (&(in_bus | ~tm)) & (&(~in_bus | ~cm));
      assign rt  = route_e'(route[2*k +: 2]);

      assign keep_v[k] = hit & (rt == RT_KEEP);
      assign up_v[k]   = hit & (rt == RT_UP);
      assign dn_v[k]   = hit & (rt == RT_DOWN);
   end

   assign keep_or = |keep_v;
   assign up_or   = |up_v;
   assign dn_or   = |dn_v;

endmodule

// File: rtl/ptalloc_steer.sv
module ptalloc_steer #(
   parameter int N_MC = 18
) (
   input  logic [N_MC-1:0] keep_or,
   input  logic [N_MC-1:0] up_or,
   input  logic [N_MC-1:0] dn_or,
   input  logic [N_MC-1:0] chain_up,
   input  logic [N_MC-1:0] chain_dn,
   output logic [N_MC-1:0] sum
);

   logic [N_MC-1:0] up_rx;
   logic [N_MC-1:0] dn_rx;

   // upward ripple: cell i receives what cell i-1 sends up
   always_comb begin
      logic carry;
      carry = 1'b0;
      for (int i = 0; i < N_MC; i++) begin
         up_rx[i] = carry;
         carry    = up_or[i] | (chain_up[i] & carry);
      end
   end

   // downward ripple: cell i receives what cell i+1 sends down
   always_comb begin
      logic carry;
      carry = 1'b0;
      for (int i = N_MC - 1; i >= 0; i--) begin
         dn_rx[i] = carry;
         carry    = dn_or[i] | (chain_dn[i] & carry);
      end
   end

   assign sum = keep_or | (up_rx & ~chain_up) | (dn_rx & ~chain_dn);

endmodule

// File: rtl/ptalloc_cell.sv
module ptalloc_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic gsr,
   input  logic gts,
   input  logic sum,
   input  logic invert,
   input  logic reg_sel,
   input  logic init_val,
   input  logic oe_cfg,
   output logic d,
   output logic q_out,
   output logic oe
);

   logic q;

   assign d = sum ^ invert;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= init_val;
      end else if (gsr) begin
         q <= init_val;
      end else begin
         q <= d;
      end
   end

   assign q_out = reg_sel ? q : d;
   assign oe    = oe_cfg & ~gts;

endmodule

// File: rtl/ptalloc_fblock.sv
module ptalloc_fblock #(
   parameter int N_IN = 36,
   parameter int N_MC = 18,
   parameter int N_PT = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        gsr,
   input  logic                        gts,
   input  logic [N_IN-1:0]             in_bus,
   input  logic [N_MC*N_PT-1:0]        pt_en,
   input  logic [N_MC*N_PT*N_IN-1:0]   pt_true,
   input  logic [N_MC*N_PT*N_IN-1:0]   pt_comp,
   input  logic [2*N_MC*N_PT-1:0]      pt_route,
   input  logic [N_MC-1:0]             chain_up,
   input  logic [N_MC-1:0]             chain_dn,
   input  logic [N_MC-1:0]             invert,
   input  logic [N_MC-1:0]             reg_sel,
   input  logic [N_MC-1:0]             init_val,
   input  logic [N_MC-1:0]             oe_cfg,
   output logic [N_MC-1:0]             mc_out,
   output logic [N_MC-1:0]             mc_oe
);

   localparam int CELL_CFG = N_PT * N_IN;
   localparam int CELL_RT  = 2 * N_PT;

   if (N_IN < 1) begin : g_bad_in
      $error("ptalloc_fblock: N_IN must be at least 1");
   end
   if (N_MC < 2) begin : g_bad_mc
      $error("ptalloc_fblock: N_MC must be at least 2 for steering");
   end
   if (N_PT < 1) begin : g_bad_pt
      $error("ptalloc_fblock: N_PT must be at least 1");
   end

   logic [N_MC-1:0] keep_or;
   logic [N_MC-1:0] up_or;
   logic [N_MC-1:0] dn_or;
   logic [N_MC-1:0] sum;
   logic [N_MC-1:0] cell_d;

   for (genvar m = 0; m < N_MC; m++) begin : g_mc
      ptalloc_terms #(
         .N_IN (N_IN),
         .N_PT (N_PT)
      ) i_terms (
         .in_bus  (in_bus),
         .en      (pt_en[m*N_PT +: N_PT]),
         .tmask   (pt_true[m*CELL_CFG +: CELL_CFG]),
         .cmask   (pt_comp[m*CELL_CFG +: CELL_CFG]),
         .route   (pt_route[m*CELL_RT +: CELL_RT]),
         .keep_or (keep_or[m]),
         .up_or   (up_or[m]),
         .dn_or   (dn_or[m])
      );

      ptalloc_cell i_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .gsr      (gsr),
         .gts      (gts),
         .sum      (sum[m]),
         .invert   (invert[m]),
         .reg_sel  (reg_sel[m]),
         .init_val (init_val[m]),
         .oe_cfg   (oe_cfg[m]),
         .d        (cell_d[m]),
         .q_out    (mc_out[m]),
         .oe       (mc_oe[m])
      );
   end

   ptalloc_steer #(
      .N_MC (N_MC)
   ) i_steer (
      .keep_or  (keep_or),
      .up_or    (up_or),
      .dn_or    (dn_or),
      .chain_up (chain_up),
      .chain_dn (chain_dn),
      .sum      (sum)
   );

endmodule

// File: rtl/ptalloc_fblock_chk.sv
module ptalloc_fblock_chk #(
   parameter int N_MC = 18
) (
   input logic            clk,
   input logic            rst_n,
   input logic            gsr,
   input logic            gts,
   input logic [N_MC-1:0] reg_sel,
   input logic [N_MC-1:0] init_val,
   input logic [N_MC-1:0] oe_cfg,
   input logic [N_MC-1:0] cell_d,
   input logic [N_MC-1:0] mc_out,
   input logic [N_MC-1:0] mc_oe
);

   AST_OE_GTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      gts |-> (mc_oe == '0));  // R9

   AST_OE_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      !gts |-> (mc_oe == oe_cfg));  // R9

   AST_GSR_LOADS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      gsr |=> (((mc_out ^ $past(init_val)) & reg_sel & $past(reg_sel)) == '0));  // R8

   AST_REG_CAPTURES_D: assert property (@(posedge clk) disable iff (!rst_n)
      !gsr |=> (((mc_out ^ $past(cell_d)) & reg_sel & $past(reg_sel)) == '0));  // R6

endmodule

bind ptalloc_fblock ptalloc_fblock_chk #(
   .N_MC (N_MC)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .gsr      (gsr),
   .gts      (gts),
   .reg_sel  (reg_sel),
   .init_val (init_val),
   .oe_cfg   (oe_cfg),
   .cell_d   (cell_d),
   .mc_out   (mc_out),
   .mc_oe    (mc_oe)
);

// File: tb/test_ptalloc_fblock.sv
module test_ptalloc_fblock;

   localparam int N_IN  = 36;
   localparam int N_MC  = 18;
   localparam int N_PT  = 5;
   localparam int TERMS = N_MC * N_PT;
   localparam int CFG_W = TERMS * N_IN;

   localparam logic [1:0] KEEP = 2'b00;
   localparam logic [1:0] UP   = 2'b01;
   localparam logic [1:0] DOWN = 2'b10;
   localparam logic [1:0] DROP = 2'b11;

   logic                clk;
   logic                rst_n;
   logic                gsr;
   logic                gts;
   logic [N_IN-1:0]     in_bus;
   logic [TERMS-1:0]    pt_en;
   logic [CFG_W-1:0]    pt_true;
   logic [CFG_W-1:0]    pt_comp;
   logic [2*TERMS-1:0]  pt_route;
   logic [N_MC-1:0]     chain_up;
   logic [N_MC-1:0]     chain_dn;
   logic [N_MC-1:0]     invert;
   logic [N_MC-1:0]     reg_sel;
   logic [N_MC-1:0]     init_val;
   logic [N_MC-1:0]     oe_cfg;
   logic [N_MC-1:0]     mc_out;
   logic [N_MC-1:0]     mc_oe;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   ptalloc_fblock #(
      .N_IN (N_IN),
      .N_MC (N_MC),
      .N_PT (N_PT)
   ) i_ptalloc_fblock (.*);

   initial clk = 1'b0;
   always #2 clk = ~clk;

   task automatic chk(input string tag, input logic [N_MC-1:0] act, input logic [N_MC-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic clear_cfg();
      pt_en    = '0;
      pt_true  = '0;
      pt_comp  = '0;
      pt_route = '0;
      chain_up = '0;
      chain_dn = '0;
      invert   = '0;
      reg_sel  = '0;
      init_val = '0;
      oe_cfg   = '0;
      gsr      = 1'b0;
      gts      = 1'b0;
      in_bus   = '0;
   endtask

   task automatic set_pt(input int mc, input int k, input logic [N_IN-1:0] tm,
                         input logic [N_IN-1:0] cm, input logic [1:0] rt);
      int idx;
      idx = mc * N_PT + k;
      pt_en[idx]               = 1'b1;
      pt_true[idx*N_IN +: N_IN] = tm;
      pt_comp[idx*N_IN +: N_IN] = cm;
      pt_route[idx*2 +: 2]     = rt;
   endtask

   function automatic logic [N_IN-1:0] bit_of(input int n);
      return {{(N_IN-1){1'b0}}, 1'b1} << n;
   endfunction

   function automatic logic [N_MC-1:0] mc_bit(input int n);
      return {{(N_MC-1){1'b0}}, 1'b1} << n;
   endfunction

   task automatic apply(input logic [N_IN-1:0] v);
      @(negedge clk);
      in_bus = v;
      #1;
   endtask

   task automatic t_reset();
      clear_cfg();
      reg_sel  = '1;
      init_val = 18'h2A5C3;
      rst_n    = 1'b0;
      repeat (2) @(negedge clk);
      chk("R7 reset loads init", mc_out, 18'h2A5C3);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R6 capture zero sum after reset", mc_out, '0);
   endtask

   task automatic t_pterm();
      clear_cfg();
      set_pt(0, 0, bit_of(0) | bit_of(1), bit_of(2), KEEP);
      apply(bit_of(0) | bit_of(1));
      chk("R1 all literals met", mc_out, mc_bit(0));
      apply(bit_of(0) | bit_of(1) | bit_of(2));
      chk("R1 complemented literal high", mc_out, '0);
      apply(bit_of(0));
      chk("R1 true literal low", mc_out, '0);
      pt_en[0] = 1'b0;
      apply(bit_of(0) | bit_of(1));
      chk("R1 disabled term", mc_out, '0);
   endtask

   task automatic t_sum_invert();
      clear_cfg();
      set_pt(3, 0, bit_of(4), '0, KEEP);
      set_pt(3, 4, bit_of(5), '0, KEEP);
      apply(bit_of(5));
      chk("R2 OR of two local terms", mc_out, mc_bit(3));
      invert[3] = 1'b1;
      apply('0);
      chk("R2 inverted empty sum", mc_out, mc_bit(3));
      apply(bit_of(4));
      chk("R2 inverted true sum", mc_out, '0);
   endtask

   task automatic t_steer();
      clear_cfg();
      set_pt(5, 0, bit_of(6), '0, UP);
      set_pt(5, 1, bit_of(7), '0, DOWN);
      apply(bit_of(6));
      chk("R3 up route lands in next cell, not donor", mc_out, mc_bit(6));
      apply(bit_of(7));
      chk("R3 down route lands in previous cell, not donor", mc_out, mc_bit(4));
   endtask

   task automatic t_chain();
      clear_cfg();
      set_pt(2, 0, bit_of(8), '0, UP);
      chain_up[3] = 1'b1;
      chain_up[4] = 1'b1;
      set_pt(10, 0, bit_of(9), '0, DOWN);
      chain_dn[9] = 1'b1;
      apply(bit_of(8));
      chk("R4 up chain over two cells", mc_out, mc_bit(5));
      apply(bit_of(9));
      chk("R4 down chain over one cell", mc_out, mc_bit(8));
   endtask

   task automatic t_edges();
      clear_cfg();
      set_pt(N_MC-1, 0, bit_of(10), '0, UP);
      set_pt(0, 0, bit_of(10), '0, DOWN);
      set_pt(1, 0, bit_of(10), '0, DROP);
      apply('1);
      chk("R5 off-end and dropped terms vanish", mc_out, '0);
   endtask

   task automatic t_reg();
      clear_cfg();
      reg_sel[7] = 1'b1;
      set_pt(7, 0, bit_of(11), '0, KEEP);
      apply('0);
      @(posedge clk);
      #1;
      chk("R6 register holds zero", mc_out, '0);
      apply(bit_of(11));
      chk("R6 no change before edge", mc_out, '0);
      @(posedge clk);
      #1;
      chk("R6 rises after edge", mc_out, mc_bit(7));
      apply('0);
      chk("R6 holds before edge", mc_out, mc_bit(7));
      @(posedge clk);
      #1;
      chk("R6 falls after edge", mc_out, '0);
   endtask

   task automatic t_gsr();
      clear_cfg();
      reg_sel[7] = 1'b1;
      set_pt(7, 0, bit_of(11), '0, KEEP);
      apply(bit_of(11));
      @(posedge clk);
      #1;
      chk("R8 preload one", mc_out, mc_bit(7));
      @(negedge clk);
      gsr = 1'b1;
      @(posedge clk);
      #1;
      chk("R8 gsr forces init zero", mc_out, '0);
      @(negedge clk);
      gsr = 1'b0;
      init_val[7] = 1'b1;
      in_bus = '0;
      @(posedge clk);
      #1;
      chk("R8 data resumes", mc_out, '0);
      @(negedge clk);
      gsr = 1'b1;
      @(posedge clk);
      #1;
      chk("R8 gsr forces init one", mc_out, mc_bit(7));
      @(negedge clk);
      gsr = 1'b0;
      rst_n = 1'b0;
      init_val[7] = 1'b0;
      #1;
      chk("R7 async reset mid cycle", mc_out, '0);
      rst_n = 1'b1;
   endtask

   task automatic t_oe();
      clear_cfg();
      oe_cfg = 18'h35A69;
      apply('0);
      chk("R9 enables follow config", mc_oe, 18'h35A69);
      gts = 1'b1;
      #1;
      chk("R9 gts clears enables", mc_oe, '0);
      gts = 1'b0;
      #1;
      chk("R9 enables restored", mc_oe, 18'h35A69);
   endtask

   task automatic t_wide();
      logic [31:0] lfsr;
      logic        e;
      clear_cfg();
      for (int j = 0; j < 5; j++) set_pt(9, j, bit_of(j) | bit_of(j+8), '0, KEEP);
      set_pt(8, 0, bit_of(5) | bit_of(13), '0, UP);
      set_pt(8, 1, bit_of(6) | bit_of(14), '0, UP);
      set_pt(10, 0, bit_of(7) | bit_of(15), '0, DOWN);
      for (int j = 0; j < 8; j++) begin
         apply(bit_of(j) | bit_of(j+8));
         chk("R10 single term of wide sum", mc_out, mc_bit(9));
         apply(bit_of(j));
         chk("R10 partial term of wide sum", mc_out, '0);
      end
      lfsr = 32'h1D2C3B4A;
      for (int n = 0; n < 16; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         apply({lfsr[3:0], lfsr} & {{20{1'b0}}, lfsr[15:0] & lfsr[31:16]});
         e = 1'b0;
         for (int j = 0; j < 8; j++) e = e | (in_bus[j] & in_bus[j+8]);
         chk("R10 random wide sum", mc_out, e ? mc_bit(9) : '0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      clear_cfg();
      rst_n = 1'b0;
      t_reset();
      t_pterm();
      t_sum_invert();
      t_steer();
      t_chain();
      t_edges();
      t_reg();
      t_gsr();
      t_oe();
      t_wide();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule